// File: doc/BRIEF.md
# Serial Interrupt Frame Peripheral

This block is the device end of a one-wire interrupt reporting scheme that runs on the PCI clock. A host owns the shared open-drain wire and opens each cycle with a low pulse. After that pulse the block counts fixed three-clock frames. The frames run in order: sixteen interrupt frames, then one channel-check frame, then a stop pulse from the host. In each frame whose request was active when the cycle began, the block pulls the wire low in the first clock and drives it high in the second. It leaves the wire undriven in the third clock. Frames for inactive requests are never driven, so the pull-up keeps the wire high and the host reads the request as clear.

The block learns the operating mode from the width of the stop pulse. In quiet mode the host stays silent until something happens. When a request input no longer matches what was last reported, the block pulls the idle wire low for one clock, and the host then stretches that pulse into a full start. In continuous mode the block never starts a cycle on its own. The block connects to an external tristate pad, which drives `drv_val` while `drv_en` is high. The resolved wire level is returned on `line_in`.

Top module: `irqser_node`

## Requirements
- R1: While `rst_n` is low, and after it has risen, the block drives nothing until a start pulse arrives. Reset selects continuous mode and sets the stored report image to all zeros.
- R2: A start is accepted when the wire, sampled while idle, stays low for at least 4 clocks (4 to 8 in normal use) and is then seen high. That high clock is the start recovery clock, and the next clock is the turnaround. The frame for request 0 begins with its sample clock 2 clocks after the recovery clock.
- R3: A low pulse shorter than 4 clocks is ignored: no frames follow and nothing is driven.
- R4: For an active request, the frame is sample, recovery and turnaround in that order. In the sample clock the block drives 0 (`drv_en`=1, `drv_val`=0). In the recovery clock it drives 1 (`drv_en`=1, `drv_val`=1). In the turnaround clock it releases the wire (`drv_en`=0).
- R5: For an inactive request, `drv_en` stays 0 for all three clocks of its frame.
- R6: Frame index n (0 to 15) carries `irq_req[n]`. Frame index 16 carries `chk_req`, and it is the last frame before the stop pulse.
- R7: All 17 request values are captured at the clock edge that ends the start recovery clock. Input changes after that edge do not alter the current cycle.
- R8: A stop pulse of exactly 2 low clocks selects quiet mode. A stop pulse of 3 or more low clocks selects continuous mode. The block releases the wire throughout the stop frame.
- R9: In quiet mode the block may start a cycle while it is idle and the wire was high in the previous clock. It does so only when the current requests differ from the last captured image. It then drives 0 for exactly one clock. With no difference it stays released.
- R10: In continuous mode, request changes while idle never make the block drive the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Resolved level of the shared wire |
| irq_req | input | 16 | Interrupt request lines, active high |
| chk_req | input | 1 | Channel-check request, active high |
| drv_en | output | 1 | High when the block drives the wire |
| drv_val | output | 1 | Level driven while `drv_en` is high |

## Verification
The assertions assume that the host never pulls the wire low during a data frame. They also assume that the host stretches the block's one-clock start pulse instead of leaving the wire high. Under those assumptions, a sampled low always leads to a driven high, and a block-initiated start never repeats on back-to-back clocks. The bench host model keeps to this. It drives low only during start and stop pulses, and it sets request inputs in clocks where the wire is already low. The exception is the deliberate change that tests the quiet-mode start. Start widths sweep 4 to 8, and stop widths are 2 and 3.

// File: rtl/irqser_node.sv
module irqser_node #(
  parameter int NIRQ      = 16,
  parameter int START_MIN = 4,
  parameter int CNTW      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_in,
  input  logic [NIRQ-1:0] irq_req,
  input  logic            chk_req,
  output logic            drv_en,
  output logic            drv_val
);
  localparam int NSLOT = NIRQ + 1;
  localparam int SW    = $clog2(NSLOT);
  localparam logic [CNTW-1:0] START_K = CNTW'(START_MIN);
  localparam logic [CNTW-1:0] STOP_Q  = CNTW'(2);
  localparam logic [CNTW-1:0] ONE     = CNTW'(1);
  localparam logic [SW-1:0]   LAST    = SW'(NSLOT - 1);

  typedef enum logic [2:0] {S_IDLE, S_KICK, S_TURN, S_FRAME, S_STOP} st_t;

  st_t              st;
  logic [CNTW-1:0]  lowcnt;
  logic [SW-1:0]    slot;
  logic [1:0]       ph;
  logic [NSLOT-1:0] img;
  logic             quiet_q;
  logic             kick_now;

  wire [NSLOT-1:0] now_v  = {chk_req, irq_req};
  wire             lowsat = &lowcnt;
  wire             pend   = now_v != img;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lowcnt  <= '0;
      slot    <= '0;
      ph      <= '0;
      img     <= '0;
      quiet_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (line_in) begin
            lowcnt <= '0;
            if (lowcnt >= START_K) begin
              st  <= S_TURN;
              img <= now_v;
            end else if (quiet_q && lowcnt == '0 && pend) begin
              st <= S_KICK;
            end
          end else if (!lowsat) begin
            lowcnt <= lowcnt + ONE;
          end
        end
        S_KICK: begin
          st     <= S_IDLE;
          lowcnt <= line_in ? '0 : ONE;
        end
        S_TURN: begin
          st   <= S_FRAME;
          slot <= '0;
          ph   <= '0;
        end
        S_FRAME: begin
          if (ph == 2'd2) begin
            ph <= '0;
            if (slot == LAST) begin
              st     <= S_STOP;
              lowcnt <= '0;
            end else begin
              slot <= slot + SW'(1);
            end
          end else begin
            ph <= ph + 2'd1;
          end
        end
        S_STOP: begin
          if (line_in) begin
            lowcnt <= '0;
            if (lowcnt >= STOP_Q) begin
              quiet_q <= (lowcnt == STOP_Q);
              st      <= S_IDLE;
            end
          end else if (!lowsat) begin
            lowcnt <= lowcnt + ONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign kick_now = (st == S_KICK);
  assign drv_en   = kick_now | (st == S_FRAME && ph != 2'd2 && img[slot]);
  assign drv_val  = (st == S_FRAME) && (ph == 2'd1);
endmodule

// File: rtl/irqser_node_chk.sv
module irqser_node_chk (
  input logic clk,
  input logic rst_n,
  input logic drv_en,
  input logic drv_val,
  input logic kick,
  input logic quiet
);
  AST_RST_RELEASE: assert property (@(posedge clk) !rst_n |=> !drv_en); // R1
  AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !drv_val && !kick) |=> (drv_en && drv_val)); // R4
  AST_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && drv_val) |=> !drv_en); // R4
  AST_KICK_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> quiet); // R9
  AST_KICK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick); // R9
endmodule

bind irqser_node irqser_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_val(drv_val),
  .kick(kick_now), .quiet(quiet_q)
);

// File: tb/irqser_node_test.sv
module irqser_node_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_low = 1'b0;
  logic        chk = 1'b0;
  logic [15:0] irq = '0;
  wire         drv_en, drv_val;
  wire         line = !host_low && !(drv_en && !drv_val);

  irqser_node uut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .irq_req(irq),
    .chk_req(chk), .drv_en(drv_en), .drv_val(drv_val)
  );

  int total = 0;
  int bad = 0;

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic int obs();
    return drv_en ? (drv_val ? 3 : 2) : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input logic [16:0] pat, input int slen, input int plen, input bit flip);
    for (int i = 0; i < slen; i++) begin
      tick();
      host_low = 1'b1;
      if (i == 0) {chk, irq} = pat;
      check("R2", obs(), 0);
    end
    tick(); host_low = 1'b0;
    check("R2", obs(), 0);
    tick();
    check("R2", obs(), 0);
    for (int n = 0; n < 17; n++) begin
      for (int p = 0; p < 3; p++) begin
        string tag;
        int exp;
        tick();
        if (flip && n == 0 && p == 0) {chk, irq} = ~pat;
        exp = (p == 2 || !pat[n]) ? 0 : (p == 0 ? 2 : 3);
        tag = flip ? "R7" : (n == 16 ? "R6" : (n == 0 ? "R2" : (pat[n] ? "R4" : "R5")));
        check(tag, obs(), exp);
      end
    end
    for (int i = 0; i < plen; i++) begin
      tick(); host_low = 1'b1;
      check("R8", obs(), 0);
    end
    tick(); host_low = 1'b0;
    check("R8", obs(), 0);
    tick();
    check("R8", obs(), 0);
  endtask

  initial begin
    repeat (3) begin
      tick();
      irq = '1; chk = 1'b1;
      check("R1", obs(), 0);
    end
    rst_n = 1'b1;
    repeat (8) begin tick(); check("R1", obs(), 0); end

    for (int i = 0; i < 3; i++) begin tick(); host_low = 1'b1; end
    tick(); host_low = 1'b0;
    repeat (60) begin tick(); check("R3", obs(), 0); end

    for (int k = 0; k < 17; k++) run_cycle(17'(1) << k, 4 + k % 5, 3, 1'b0);
    run_cycle(17'h00000, 8, 3, 1'b0);
    run_cycle(17'h1FFFF, 4, 3, 1'b0);
    run_cycle(17'h0AAAA, 6, 4, 1'b0);
    run_cycle(17'h15555, 5, 3, 1'b0);

    run_cycle(17'h1A5C3, 6, 3, 1'b1);
    repeat (8) begin tick(); check("R10", obs(), 0); end

    run_cycle(17'h03C0F, 5, 2, 1'b0);
    repeat (8) begin tick(); check("R9", obs(), 0); end
    tick(); {chk, irq} = 17'h10F01;
    check("R9", obs(), 0);
    tick(); check("R9", obs(), 2);
    run_cycle(17'h10F01, 4, 2, 1'b0);
    repeat (6) begin tick(); check("R9", obs(), 0); end

    run_cycle(17'h0F0F0, 7, 3, 1'b0);
    tick(); {chk, irq} = 17'h00001;
    repeat (10) begin tick(); check("R8", obs(), 0); end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule